// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block is a multi-cycle engine that walks a run of bytes in memory, one element per iteration. Four operation families are supported. A copy moves a byte from a source pointer to a destination pointer. A search compares a reference byte with memory and stops early on a hit. A port-in reads a byte from an I/O port into memory. A port-out sends a byte from memory to an I/O port. Each element steps the pointer or pointers up or down and decrements a count. The copy and search families use a 16-bit count. The I/O families use only the low 8 bits of the count.

A request is launched with a one-cycle start strobe. The strobe carries the family, the direction, the repeat/single choice, the initial pointers, the count, the reference byte, the port low byte and the incoming flags. In single mode the block handles exactly one element. In repeat mode it iterates until the stop rule of the family holds. The memory and I/O request channels follow valid/ready rules. A request stays asserted with a stable address, write enable and write data until ready is seen high at a clock edge. Read data is taken in the cycle in which the matching read-valid input is high, and read-valid is never back-pressured.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and neither mem_req_valid_o nor io_req_valid_o is asserted.
- R2: A copy element reads memory at the source pointer and writes that byte to the destination pointer. Both pointers then move one place, and the 16-bit count decreases by one.
- R3: Flags are packed as bit3 sign, bit2 zero, bit1 parity/overflow (PV), bit0 carry, and are loaded from flags_i at start. A copy element clears PV when the new count is zero and sets it otherwise. Sign, zero and carry keep their loaded values.
- R4: A search element reads memory at the source pointer and compares it with acc_i. Zero is set when they are equal. Sign is bit 7 of acc_i minus the byte. PV is 1 when the new count is non-zero. Carry is kept. No write is made to memory or to a port.
- R5: A repeated search stops at the first element that matches or that takes the count to zero. After a match the source pointer is already one place beyond the matching byte.
- R6: A port-in element reads the port at address {count[7:0], port_i} (count value before the decrement) and writes the byte to memory at the source pointer. A port-out element reads memory at the source pointer and writes the byte to that port address. Only count[7:0] decrements, and count[15:8] and the destination pointer are unchanged. Zero reflects the new 8-bit count and sign its bit 7, while PV and carry are kept.
- R7: A repeated I/O operation stops only when the 8-bit count becomes zero.
- R8: With dir_down_i at 0 the pointers increase by one per element, and with it at 1 they decrease by one. Both wrap modulo 2^16.
- R9: A repeated copy runs until the count becomes zero, leaving count 0 and PV 0.
- R10: In single mode exactly one element is processed before done_o, whatever the count.
- R11: A start strobe while busy_o is 1 is ignored and does not alter the running operation.
- R12: A request held without ready keeps its valid, address, write enable and data stable, and stalls on either channel change no result.
- R13: busy_o is 1 from the cycle after an accepted start until completion. done_o is a one-cycle pulse in the first cycle in which busy_o is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle launch strobe |
| op_i | input | 2 | Family: 00 copy, 01 search, 10 port-in, 11 port-out |
| dir_down_i | input | 1 | 1 = pointers decrement, 0 = increment |
| repeat_i | input | 1 | 1 = repeat until stop rule, 0 = single element |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 16 | Initial count |
| acc_i | input | 8 | Reference byte for search |
| port_i | input | 8 | Low byte of the port address |
| flags_i | input | 4 | Incoming flags {S,Z,PV,C} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| src_o | output | 16 | Current source pointer |
| dst_o | output | 16 | Current destination pointer |
| cnt_o | output | 16 | Current count |
| flags_o | output | 4 | Current flags {S,Z,PV,C} |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request ready |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 8 | Memory read data |
| io_req_valid_o | output | 1 | Port request valid |
| io_req_ready_i | input | 1 | Port request ready |
| io_we_o | output | 1 | Port request is a write |
| io_addr_o | output | 16 | Port address {count low byte, port_i} |
| io_wdata_o | output | 8 | Port write data |
| io_rvalid_i | input | 1 | Port read data valid |
| io_rdata_i | input | 8 | Port read data |

## Verification
Copies are run upward and downward, in single and repeat mode, and across the top of the address space. These runs separate the direction handling, the pointer wrap and the count-driven PV result. Searches use one run whose hit sits in the middle of the data and one with no hit at all. This shows whether the stop comes from the match or from the count, and where the pointer ends up. Port reads and writes use count values whose upper byte is non-zero, so an 8-bit versus 16-bit count, a wrong port address byte and a moved destination pointer each give a visibly wrong result. Back-pressure runs toggle ready, and a second start during a busy run checks that it is ignored.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;

  typedef enum logic [1:0] {
    FAM_COPY   = 2'b00,
    FAM_SEARCH = 2'b01,
    FAM_PIN    = 2'b10,
    FAM_POUT   = 2'b11
  } fam_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WR    = 3'd3,
    ST_STEP  = 3'd4
  } st_e;

  typedef struct packed {
    logic s;
    logic z;
    logic pv;
    logic c;
  } flags_t;

endpackage

// File: rtl/blk_ptr_reg.sv
module blk_ptr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         dn_i,
  input  logic [W-1:0] init_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= init_i;
    end else if (step_i) begin
      q_o <= dn_i ? (q_o - W'(1)) : (q_o + W'(1));
    end
  end

  assert_ptr_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> (q_o != $past(q_o)));

endmodule

// File: rtl/blk_ptr_unit.sv
module blk_ptr_unit #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int IO_CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                dn_i,
  input  logic                dst_en_i,
  input  logic                io_mode_i,
  input  logic [ADDR_W-1:0]   src_init_i,
  input  logic [ADDR_W-1:0]   dst_init_i,
  input  logic [CNT_W-1:0]    cnt_init_i,
  output logic [ADDR_W-1:0]   src_o,
  output logic [ADDR_W-1:0]   dst_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W-1:0]    cnt_next_o,
  output logic [IO_CNT_W-1:0] io_cnt_next_o
);

  localparam int NPTR = 2;
  localparam int HI_W = CNT_W - IO_CNT_W;

  logic [ADDR_W-1:0] init_w [NPTR];
  logic [ADDR_W-1:0] ptr_w  [NPTR];
  logic [NPTR-1:0]   en_w;
  logic [CNT_W-1:0]  cnt_q;

  assign init_w[0] = src_init_i;
  assign init_w[1] = dst_init_i;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    assign en_w[i] = step_i && ((i == 0) || dst_en_i);
    blk_ptr_reg #(.W(ADDR_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .step_i (en_w[i]),
      .dn_i   (dn_i),
      .init_i (init_w[i]),
      .q_o    (ptr_w[i])
    );
  end

  assign src_o = ptr_w[0];
  assign dst_o = ptr_w[1];

  assign io_cnt_next_o = cnt_q[IO_CNT_W-1:0] - IO_CNT_W'(1);
  assign cnt_next_o    = io_mode_i ? {cnt_q[CNT_W-1:IO_CNT_W], io_cnt_next_o}
                                   : (cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_init_i;
    end else if (step_i) begin
      cnt_q <= cnt_next_o;
    end
  end

  assign cnt_o = cnt_q;

  logic [HI_W-1:0] cnt_hi_w;
  assign cnt_hi_w = cnt_q[CNT_W-1:IO_CNT_W];

  assert_io_hi_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && io_mode_i && !load_i |=> $stable(cnt_hi_w));

endmodule

// File: rtl/blk_flag_unit.sv
module blk_flag_unit
  import blk_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IO_CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                step_i,
  input  fam_e                fam_i,
  input  logic [3:0]          flags_init_i,
  input  logic [DATA_W-1:0]   acc_init_i,
  input  logic [DATA_W-1:0]   rbyte_i,
  input  logic                cnt_next_zero_i,
  input  logic [IO_CNT_W-1:0] io_cnt_next_i,
  output logic                match_o,
  output logic [3:0]          flags_o
);

  flags_t            fl_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] diff_w;

  assign diff_w  = acc_q - rbyte_i;
  assign match_o = (acc_q == rbyte_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      fl_q  <= flags_t'(flags_init_i);
      acc_q <= acc_init_i;
    end else if (step_i) begin
      unique case (fam_i)
        FAM_COPY: begin
          fl_q.pv <= !cnt_next_zero_i;
        end
        FAM_SEARCH: begin
          fl_q.z  <= match_o;
          fl_q.s  <= diff_w[DATA_W-1];
          fl_q.pv <= !cnt_next_zero_i;
        end
        default: begin
          fl_q.z <= (io_cnt_next_i == '0);
          fl_q.s <= io_cnt_next_i[IO_CNT_W-1];
        end
      endcase
    end
  end

  assign flags_o = fl_q;

  logic [2:0] szc_w;
  assign szc_w = {fl_q.s, fl_q.z, fl_q.c};

  assert_copy_flags_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && (fam_i == FAM_COPY) |=> $stable(szc_w));

  assert_carry_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> $stable(fl_q.c));

endmodule

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int IO_CNT_W = 8,
  parameter int PORT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [1:0]                 op_i,
  input  logic                       dir_down_i,
  input  logic                       repeat_i,
  input  logic [PORT_W-1:0]          port_i,
  input  logic [ADDR_W-1:0]          src_i,
  input  logic [ADDR_W-1:0]          dst_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [CNT_W-1:0]           cnt_next_i,
  input  logic [IO_CNT_W-1:0]        io_cnt_next_i,
  input  logic                       match_i,
  output logic                       load_o,
  output logic                       step_o,
  output logic                       dn_o,
  output logic                       dst_en_o,
  output logic                       io_mode_o,
  output fam_e                       fam_o,
  output logic [DATA_W-1:0]          rbyte_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       mem_req_valid_o,
  input  logic                       mem_req_ready_i,
  output logic                       mem_we_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  input  logic                       mem_rvalid_i,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  output logic                       io_req_valid_o,
  input  logic                       io_req_ready_i,
  output logic                       io_we_o,
  output logic [IO_CNT_W+PORT_W-1:0] io_addr_o,
  output logic [DATA_W-1:0]          io_wdata_o,
  input  logic                       io_rvalid_i,
  input  logic [DATA_W-1:0]          io_rdata_i
);

  st_e               st_q, st_d;
  fam_e              fam_q;
  logic              rep_q, dn_q, done_q;
  logic [PORT_W-1:0] port_q;
  logic [DATA_W-1:0] data_q;
  logic              is_pin, is_pout, is_copy, is_srch;
  logic              rd_fire, wr_fire, rv_w, fin_w;

  assign is_pin  = (fam_q == FAM_PIN);
  assign is_pout = (fam_q == FAM_POUT);
  assign is_copy = (fam_q == FAM_COPY);
  assign is_srch = (fam_q == FAM_SEARCH);

  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign step_o    = (st_q == ST_STEP);
  assign dn_o      = dn_q;
  assign dst_en_o  = is_copy;
  assign io_mode_o = is_pin || is_pout;
  assign fam_o     = fam_q;
  assign rbyte_o   = data_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;

  // request channels
  always_comb begin
    mem_req_valid_o = 1'b0;
    io_req_valid_o  = 1'b0;
    if (st_q == ST_RD) begin
      mem_req_valid_o = !is_pin;
      io_req_valid_o  = is_pin;
    end else if (st_q == ST_WR) begin
      mem_req_valid_o = is_copy || is_pin;
      io_req_valid_o  = is_pout;
    end
  end

  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = ((st_q == ST_WR) && is_copy) ? dst_i : src_i;
  assign mem_wdata_o = data_q;
  assign io_we_o     = (st_q == ST_WR);
  assign io_addr_o   = {cnt_i[IO_CNT_W-1:0], port_q};
  assign io_wdata_o  = data_q;

  assign rd_fire = (mem_req_valid_o && mem_req_ready_i) || (io_req_valid_o && io_req_ready_i);
  assign wr_fire = rd_fire;
  assign rv_w    = is_pin ? io_rvalid_i : mem_rvalid_i;

  // stop rule per family
  always_comb begin
    if (!rep_q) begin
      fin_w = 1'b1;
    end else begin
      unique case (fam_q)
        FAM_COPY:   fin_w = (cnt_next_i == '0);
        FAM_SEARCH: fin_w = (cnt_next_i == '0) || match_i;
        default:    fin_w = (io_cnt_next_i == '0);
      endcase
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_RD;
      ST_RD:    if (rd_fire) st_d = ST_RWAIT;
      ST_RWAIT: if (rv_w) st_d = is_srch ? ST_STEP : ST_WR;
      ST_WR:    if (wr_fire) st_d = ST_STEP;
      ST_STEP:  st_d = fin_w ? ST_IDLE : ST_RD;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fam_q  <= FAM_COPY;
      rep_q  <= 1'b0;
      dn_q   <= 1'b0;
      port_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_STEP) && fin_w;
      if (load_o) begin
        fam_q  <= fam_e'(op_i);
        rep_q  <= repeat_i;
        dn_q   <= dir_down_i;
        port_q <= port_i;
      end
      if ((st_q == ST_RWAIT) && rv_w) begin
        data_q <= is_pin ? io_rdata_i : mem_rdata_i;
      end
    end
  end

  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_io_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid_o && !io_req_ready_i |=>
      io_req_valid_o && $stable(io_addr_o) && $stable(io_we_o) && $stable(io_wdata_o));

  assert_one_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid_o, io_req_valid_o}));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);

  assert_copy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && rep_q && is_copy |-> (cnt_i == '0));

  assert_io_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && rep_q && io_mode_o |-> (cnt_i[IO_CNT_W-1:0] == '0));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int IO_CNT_W = 8,
  parameter int PORT_W   = 8,
  localparam int IOA_W   = IO_CNT_W + PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              dir_down_i,
  input  logic              repeat_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [3:0]        flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [3:0]        flags_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              io_req_valid_o,
  input  logic              io_req_ready_i,
  output logic              io_we_o,
  output logic [IOA_W-1:0]  io_addr_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic              io_rvalid_i,
  input  logic [DATA_W-1:0] io_rdata_i
);

  logic                load_w, step_w, dn_w, dst_en_w, io_mode_w, match_w;
  fam_e                fam_w;
  logic [DATA_W-1:0]   rbyte_w;
  logic [CNT_W-1:0]    cnt_next_w;
  logic [IO_CNT_W-1:0] io_cnt_next_w;

  blk_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .IO_CNT_W(IO_CNT_W), .PORT_W(PORT_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .op_i            (op_i),
    .dir_down_i      (dir_down_i),
    .repeat_i        (repeat_i),
    .port_i          (port_i),
    .src_i           (src_o),
    .dst_i           (dst_o),
    .cnt_i           (cnt_o),
    .cnt_next_i      (cnt_next_w),
    .io_cnt_next_i   (io_cnt_next_w),
    .match_i         (match_w),
    .load_o          (load_w),
    .step_o          (step_w),
    .dn_o            (dn_w),
    .dst_en_o        (dst_en_w),
    .io_mode_o       (io_mode_w),
    .fam_o           (fam_w),
    .rbyte_o         (rbyte_w),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .mem_rvalid_i    (mem_rvalid_i),
    .mem_rdata_i     (mem_rdata_i),
    .io_req_valid_o  (io_req_valid_o),
    .io_req_ready_i  (io_req_ready_i),
    .io_we_o         (io_we_o),
    .io_addr_o       (io_addr_o),
    .io_wdata_o      (io_wdata_o),
    .io_rvalid_i     (io_rvalid_i),
    .io_rdata_i      (io_rdata_i)
  );

  blk_ptr_unit #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IO_CNT_W(IO_CNT_W)
  ) u_ptr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_w),
    .step_i        (step_w),
    .dn_i          (dn_w),
    .dst_en_i      (dst_en_w),
    .io_mode_i     (io_mode_w),
    .src_init_i    (src_i),
    .dst_init_i    (dst_i),
    .cnt_init_i    (cnt_i),
    .src_o         (src_o),
    .dst_o         (dst_o),
    .cnt_o         (cnt_o),
    .cnt_next_o    (cnt_next_w),
    .io_cnt_next_o (io_cnt_next_w)
  );

  blk_flag_unit #(
    .DATA_W(DATA_W), .IO_CNT_W(IO_CNT_W)
  ) u_flag (
    .clk             (clk),
    .rst_n           (rst_n),
    .load_i          (load_w),
    .step_i          (step_w),
    .fam_i           (fam_w),
    .flags_init_i    (flags_i),
    .acc_init_i      (acc_i),
    .rbyte_i         (rbyte_w),
    .cnt_next_zero_i (cnt_next_w == '0),
    .io_cnt_next_i   (io_cnt_next_w),
    .match_o         (match_w),
    .flags_o         (flags_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o && !io_req_valid_o);

endmodule

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 0, dir_down_i = 0, repeat_i = 0;
  logic [1:0]  op_i = 0;
  logic [15:0] src_i = 0, dst_i = 0, cnt_i = 0;
  logic [7:0]  acc_i = 0, port_i = 0;
  logic [3:0]  flags_i = 0;
  logic        busy_o, done_o;
  logic [15:0] src_o, dst_o, cnt_o;
  logic [3:0]  flags_o;
  logic        mem_req_valid_o, mem_we_o, io_req_valid_o, io_we_o;
  logic [15:0] mem_addr_o, io_addr_o;
  logic [7:0]  mem_wdata_o, io_wdata_o;
  logic        mem_ready = 1, io_ready = 1, mem_rvalid = 0, io_rvalid = 0;
  logic [7:0]  mem_rdata = 0, io_rdata = 0;

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .dir_down_i(dir_down_i), .repeat_i(repeat_i), .src_i(src_i),
    .dst_i(dst_i), .cnt_i(cnt_i), .acc_i(acc_i), .port_i(port_i),
    .flags_i(flags_i), .busy_o(busy_o), .done_o(done_o), .src_o(src_o),
    .dst_o(dst_o), .cnt_o(cnt_o), .flags_o(flags_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_ready),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .io_req_valid_o(io_req_valid_o), .io_req_ready_i(io_ready),
    .io_we_o(io_we_o), .io_addr_o(io_addr_o), .io_wdata_o(io_wdata_o),
    .io_rvalid_i(io_rvalid), .io_rdata_i(io_rdata)
  );

  logic [7:0]  mem [65536];
  int          mem_wr_cnt, io_wr_cnt, io_rd_cnt;
  logic [15:0] io_last_addr;
  logic [7:0]  io_last_data;
  logic        stall = 0;
  int          checks = 0, fails = 0;

  // back-pressure pattern
  always @(negedge clk) begin
    mem_ready <= stall ? ~mem_ready : 1'b1;
    io_ready  <= stall ? ~io_ready  : 1'b1;
  end

  // memory and port models: read data one cycle after acceptance
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    io_rvalid  <= 1'b0;
    if (mem_req_valid_o && mem_ready) begin
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        mem_wr_cnt <= mem_wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr_o];
      end
    end
    if (io_req_valid_o && io_ready) begin
      if (io_we_o) begin
        io_last_addr <= io_addr_o;
        io_last_data <= io_wdata_o;
        io_wr_cnt    <= io_wr_cnt + 1;
      end else begin
        io_rvalid <= 1'b1;
        io_rdata  <= io_addr_o[15:8] + io_addr_o[7:0];
        io_rd_cnt <= io_rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    mem_wr_cnt = 0; io_wr_cnt = 0; io_rd_cnt = 0;
  endtask

  task automatic run(input logic [1:0] op, input logic dn, input logic rep,
                     input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                     input logic [7:0] a, input logic [7:0] p, input logic [3:0] f);
    int n;
    @(negedge clk);
    clear_logs();
    op_i = op; dir_down_i = dn; repeat_i = rep; src_i = s; dst_i = d;
    cnt_i = c; acc_i = a; port_i = p; flags_i = f; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R13 busy after start", busy_o, 1);
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R13 done reached", (n < 5000), 1);
    chk("R13 busy low with done", busy_o, 0);
    @(negedge clk);
    chk("R13 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 mem req", mem_req_valid_o, 0);
    chk("R1 io req", io_req_valid_o, 0);
  endtask

  task automatic t_copy_single();
    mem[16'h0100] = 8'hAB;
    run(2'b00, 0, 0, 16'h0100, 16'h0200, 16'd3, 8'h00, 8'h00, 4'b1001);
    chk("R2 byte copied", mem[16'h0200], 8'hAB);
    chk("R2 src", src_o, 16'h0101);
    chk("R2 dst", dst_o, 16'h0201);
    chk("R10 single count", cnt_o, 16'd2);
    chk("R3 flags pv set", flags_o, 4'b1011);
  endtask

  task automatic t_copy_repeat_down();
    mem[16'h0300] = 8'hA0; mem[16'h0301] = 8'hA1; mem[16'h0302] = 8'hA2;
    stall = 1;
    run(2'b00, 1, 1, 16'h0302, 16'h0402, 16'd3, 8'h00, 8'h00, 4'b1111);
    stall = 0;
    chk("R9 byte0 R12", mem[16'h0400], 8'hA0);
    chk("R9 byte1 R12", mem[16'h0401], 8'hA1);
    chk("R9 byte2 R12", mem[16'h0402], 8'hA2);
    chk("R8 src down", src_o, 16'h02FF);
    chk("R8 dst down", dst_o, 16'h03FF);
    chk("R9 count zero", cnt_o, 16'd0);
    chk("R3 flags pv clear", flags_o, 4'b1101);
    chk("R9 writes", mem_wr_cnt, 3);
  endtask

  task automatic t_wrap();
    mem[16'hFFFF] = 8'h6D;
    run(2'b00, 0, 0, 16'hFFFF, 16'h0010, 16'd1, 8'h00, 8'h00, 4'b0000);
    chk("R8 wrap src", src_o, 16'h0000);
    chk("R2 wrap byte", mem[16'h0010], 8'h6D);
    chk("R3 pv count1", flags_o, 4'b0000);
  endtask

  task automatic t_search_match();
    mem[16'h0500] = 8'h11; mem[16'h0501] = 8'h22; mem[16'h0502] = 8'h33;
    mem[16'h0503] = 8'h44; mem[16'h0504] = 8'h55;
    run(2'b01, 0, 1, 16'h0500, 16'h0A00, 16'd5, 8'h33, 8'h00, 4'b0001);
    chk("R5 ptr past match", src_o, 16'h0503);
    chk("R5 count at match", cnt_o, 16'd2);
    chk("R4 flags match", flags_o, 4'b0111);
    chk("R4 no writes", mem_wr_cnt + io_wr_cnt, 0);
    chk("R4 dst kept", dst_o, 16'h0A00);
  endtask

  task automatic t_search_nomatch();
    run(2'b01, 0, 1, 16'h0500, 16'h0A00, 16'd4, 8'h99, 8'h00, 4'b0000);
    chk("R5 ptr end", src_o, 16'h0504);
    chk("R5 count zero", cnt_o, 16'd0);
    chk("R4 flags nomatch", flags_o, 4'b0000);
  endtask

  task automatic t_search_single_down();
    run(2'b01, 1, 0, 16'h0503, 16'h0000, 16'd2, 8'h10, 8'h00, 4'b0000);
    chk("R8 search down ptr", src_o, 16'h0502);
    chk("R10 search single count", cnt_o, 16'd1);
    chk("R4 sign from diff", flags_o, 4'b1010);
  endtask

  task automatic t_port_in_repeat();
    stall = 1;
    run(2'b10, 0, 1, 16'h0600, 16'h1234, 16'hAB03, 8'h00, 8'h7E, 4'b1011);
    stall = 0;
    chk("R6 in byte0 R12", mem[16'h0600], 8'h81);
    chk("R6 in byte1", mem[16'h0601], 8'h80);
    chk("R6 in byte2", mem[16'h0602], 8'h7F);
    chk("R7 reads", io_rd_cnt, 3);
    chk("R6 high count kept", cnt_o, 16'hAB00);
    chk("R6 src", src_o, 16'h0603);
    chk("R6 dst kept", dst_o, 16'h1234);
    chk("R6 flags", flags_o, 4'b0111);
  endtask

  task automatic t_port_out();
    mem[16'h0700] = 8'h5C;
    run(2'b11, 1, 0, 16'h0700, 16'h0000, 16'h0001, 8'h00, 8'h12, 4'b0000);
    chk("R6 out addr", io_last_addr, 16'h0112);
    chk("R6 out data", io_last_data, 8'h5C);
    chk("R8 out ptr down", src_o, 16'h06FF);
    chk("R6 out z", flags_o, 4'b0100);
    mem[16'h0710] = 8'h31; mem[16'h0711] = 8'h32;
    run(2'b11, 0, 1, 16'h0710, 16'h0000, 16'h5502, 8'h00, 8'h40, 4'b0000);
    chk("R7 out writes", io_wr_cnt, 2);
    chk("R6 out last addr", io_last_addr, 16'h0140);
    chk("R6 out last data", io_last_data, 8'h32);
    chk("R7 out count", cnt_o, 16'h5500);
    chk("R6 out mem untouched", mem_wr_cnt, 0);
  endtask

  task automatic t_start_while_busy();
    int n;
    mem[16'h0800] = 8'h01; mem[16'h0801] = 8'h02;
    mem[16'h0802] = 8'h03; mem[16'h0803] = 8'h04;
    stall = 1;
    @(negedge clk);
    clear_logs();
    op_i = 2'b00; dir_down_i = 0; repeat_i = 1; src_i = 16'h0800;
    dst_i = 16'h0900; cnt_i = 16'd4; flags_i = 4'b0000; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    op_i = 2'b01; src_i = 16'h0F00; cnt_i = 16'd1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    stall = 0;
    chk("R11 src", src_o, 16'h0804);
    chk("R11 dst", dst_o, 16'h0904);
    chk("R11 count", cnt_o, 16'd0);
    chk("R11 last byte", mem[16'h0903], 8'h04);
    n = 0;
    repeat (6) begin
      @(negedge clk);
      if (busy_o || done_o) n++;
    end
    chk("R11 no second run", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_copy_single();
    t_copy_repeat_down();
    t_wrap();
    t_search_match();
    t_search_nomatch();
    t_search_single_down();
    t_port_in_repeat();
    t_port_out();
    t_start_while_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule